// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is a single-channel serial peripheral interface master that exchanges one word with one slave per transfer. It drives the serial clock and the outgoing data line and samples the incoming data line, shifting most significant bit first in both directions. Slave selection is left to logic outside the block.

All timing comes from the system clock together with an externally supplied enable strobe. Each system-clock cycle in which the strobe is high moves the serial clock by half a period. The strobe must therefore run at twice the wanted serial clock rate. If it is tied high, the system clock itself must be twice the serial rate. Clock polarity and clock phase are live inputs that select any of the four standard modes. They are read when a transfer is accepted.

The host presents a word, pulses `start` while `ready` is high and waits for `ready` to return. When `ready` returns, `rd_word` holds the word received from the slave. The word width is the parameter `WORD_W`, with a default of 8.

Top module: `spi_xfer_engine`

## Requirements
- R1: While idle, `ready` is 1 and `sclk` equals the `cpol` input of the previous cycle. A synchronous active-low reset leaves `ready` at 1, `rd_word` at 0 and `mosi` at 0.
- R2: `start` sampled high while `ready` is 1 is accepted. `ready` is 0 in the following cycle. The word on `wr_word` and the `cpol`/`cpha` levels of the acceptance cycle are the ones used for the transfer.
- R3: While `ready` is 0, changes on `start`, `wr_word`, `cpol` and `cpha` have no effect on the running transfer.
- R4: During a transfer, `sclk` toggles in exactly those cycles where `tick_en` is high. It does not toggle in the acceptance cycle.
- R5: A transfer consists of exactly 2*`WORD_W` serial clock edges. In the cycle after the last edge, `ready` is 1 and `sclk` is back at the polarity level of the transfer.
- R6: Bits are sent most significant first. With `cpha`=0, the first bit is on `mosi` before the first edge and `mosi` changes on trailing (even-numbered, counting from 1) edges. With `cpha`=1, `mosi` changes on leading (odd-numbered) edges.
- R7: `miso` is sampled most significant first. Sampling uses leading edges when `cpha`=0 and trailing edges when `cpha`=1. The received word appears on `rd_word` in the same cycle that `ready` rises.
- R8: `rd_word` changes only at the completion of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Half-period strobe for the serial clock, aligned to clk |
| cpol | input | 1 | Clock polarity: idle level of sclk |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges |
| start | input | 1 | Request a transfer (honoured while ready is 1) |
| wr_word | input | WORD_W | Word to transmit |
| rd_word | output | WORD_W | Last received word |
| ready | output | 1 | Idle / previous transfer complete |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
Two cases can land in the same cycle. First, a `tick_en` strobe can coincide with the acceptance of `start`. Second, a new `start` can be issued in the very cycle `ready` returns, while the final received bit is still being committed. The bench provokes both by holding `tick_en` permanently high in half of the sweep and by starting the next transfer immediately after `ready` is seen. It judges the result by the slave-side count of serial edges, which must be exactly 2*`WORD_W`, and by the words exchanged in both directions. The sweep covers every transmit word of a 4-bit configuration in all four modes. In the other half of the sweep, the strobe is sparse, and any serial clock toggle in a cycle without a strobe is reported.

// File: rtl/spi_xfer_pkg.sv
// Package: shared mode type and edge-role helpers for the SPI shift engine.
// Assumes edges are numbered from 0 within a transfer; even = leading.
package spi_xfer_pkg;

    typedef struct packed {
        logic pol;
        logic pha;
    } spi_mode_t;

    // True when the current edge is one on which the incoming line is sampled.
    function automatic logic sample_edge(input spi_mode_t m, input logic lead);
        return lead ^ m.pha;
    endfunction

    // True when the current edge is one on which the outgoing line advances.
    function automatic logic launch_edge(input spi_mode_t m, input logic lead,
                                         input logic last);
        return m.pha ? lead : (!lead && !last);
    endfunction

endpackage

// File: rtl/spi_edge_timer.sv
// Module: spi_edge_timer
// Generates the serial clock and numbers its edges within one transfer.
// Assumes: tick is a clk-aligned strobe, one strobe = one half period;
// accept arrives only while idle.
module spi_edge_timer #(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic accept,
    input  logic pol_live,
    input  logic pol_held,
    output logic active,
    output logic sclk,
    output logic edge_fire,
    output logic lead_edge,
    output logic last_edge
);

    localparam int EDGES = 2 * WORD_W;
    localparam int CW    = $clog2(EDGES);

    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic          sclk_q;

    assign active    = active_q;
    assign sclk      = sclk_q;
    assign edge_fire = active_q && tick;
    assign lead_edge = ~cnt_q[0];
    assign last_edge = (cnt_q == CW'(EDGES - 1));

    // Purpose: run the edge counter and toggle the serial clock per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            sclk_q   <= pol_live;
        end else if (accept) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            sclk_q   <= pol_live;
        end else if (edge_fire) begin
            sclk_q <= ~sclk_q;
            if (last_edge) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (!active_q) begin
            sclk_q <= pol_live;
        end
    end

    a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !accept) |=> (sclk == $past(pol_live)));

    a_r4_no_tick_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(sclk));

    a_r4_tick_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick) |=> (sclk != $past(sclk)));

    a_r3_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !(tick && last_edge)) |=>
            (active && cnt_q == $past(cnt_q) + CW'($past(tick))));

    a_r5_rest_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_fire && last_edge) |=> (!active && sclk == pol_held));

endmodule

// File: rtl/spi_tx_shifter.sv
// Module: spi_tx_shifter
// Holds the outgoing word and presents it MSB first on the data line.
// Assumes: load and edge_fire never coincide; mode is the effective mode
// (live at load, latched afterwards).
module spi_tx_shifter #(
    parameter int WORD_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [WORD_W-1:0]        wr_word,
    input  spi_xfer_pkg::spi_mode_t  mode,
    input  logic                     edge_fire,
    input  logic                     lead_edge,
    input  logic                     last_edge,
    output logic                     mosi
);

    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] src;
    logic              launch;
    logic              mosi_q;

    assign mosi   = mosi_q;
    assign src    = load ? wr_word : tx_q;
    assign launch = (load && !mode.pha) ||
                    (edge_fire && spi_xfer_pkg::launch_edge(mode, lead_edge, last_edge));

    // Purpose: capture the word and advance the outgoing bit on launch events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (launch) begin
            mosi_q <= src[WORD_W-1];
            tx_q   <= {src[WORD_W-2:0], 1'b0};
        end else if (load) begin
            tx_q <= wr_word;
        end
    end

    a_r6_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch) |=> $stable(mosi));

    a_r6_first_bit_early: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !mode.pha) |=> (mosi == $past(wr_word[WORD_W-1])));

endmodule

// File: rtl/spi_rx_shifter.sv
// Module: spi_rx_shifter
// Collects incoming bits MSB first and publishes the word at completion.
// Assumes: sample_now and finish are single-cycle strobes from the timer.
module spi_rx_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_now,
    input  logic              finish,
    input  logic              miso,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] rx_q;
    logic [WORD_W-1:0] rx_next;
    logic [WORD_W-1:0] rd_q;

    assign rx_next = {rx_q[WORD_W-2:0], miso};
    assign rd_word = rd_q;

    // Purpose: shift in sampled bits and load the result register at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
            rd_q <= '0;
        end else begin
            if (sample_now) begin
                rx_q <= rx_next;
            end
            if (finish) begin
                rd_q <= sample_now ? rx_next : rx_q;
            end
        end
    end

    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!finish) |=> $stable(rd_word));

    a_r7_last_sample_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && sample_now) |=> (rd_word[0] == $past(miso)));

endmodule

// File: rtl/spi_xfer_engine.sv
// Module: spi_xfer_engine (top)
// Single-word SPI master: accepts a start, runs 2*WORD_W serial edges paced
// by tick_en, and reports completion on ready with the received word.
// Assumes: chip select is driven elsewhere; WORD_W >= 2.
module spi_xfer_engine #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              start,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word,
    output logic              ready,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    import spi_xfer_pkg::*;

    spi_mode_t mode_q;
    spi_mode_t mode_live;
    spi_mode_t mode_eff;
    logic      active;
    logic      accept;
    logic      edge_fire;
    logic      lead_edge;
    logic      last_edge;
    logic      sample_now;
    logic      finish;

    assign mode_live  = '{pol: cpol, pha: cpha};
    assign ready      = !active;
    assign accept     = start && ready;
    assign mode_eff   = accept ? mode_live : mode_q;
    assign sample_now = edge_fire && sample_edge(mode_q, lead_edge);
    assign finish     = edge_fire && last_edge;

    // Purpose: latch the bus mode at acceptance so pin changes mid-transfer are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (accept) begin
            mode_q <= mode_live;
        end
    end

    spi_edge_timer #(.WORD_W(WORD_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .accept    (accept),
        .pol_live  (cpol),
        .pol_held  (mode_q.pol),
        .active    (active),
        .sclk      (sclk),
        .edge_fire (edge_fire),
        .lead_edge (lead_edge),
        .last_edge (last_edge)
    );

    spi_tx_shifter #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .wr_word   (wr_word),
        .mode      (mode_eff),
        .edge_fire (edge_fire),
        .lead_edge (lead_edge),
        .last_edge (last_edge),
        .mosi      (mosi)
    );

    spi_rx_shifter #(.WORD_W(WORD_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_now (sample_now),
        .finish     (finish),
        .miso       (miso),
        .rd_word    (rd_word)
    );

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);

    a_r5_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> ready);

    a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready) |=> $stable(mode_q));

endmodule

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
// Bench: sweeps every 4-bit transmit word in all four modes, with dense and
// sparse strobes, using a behavioural slave that counts serial edges.
module tb_spi_xfer_engine;

    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b1;
    logic          cpol = 1'b0;
    logic          cpha = 1'b0;
    logic          start = 1'b0;
    logic [BW-1:0] wr_word = '0;
    logic [BW-1:0] rd_word;
    logic          ready;
    logic          sclk;
    logic          mosi;
    logic          miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    // slave model state
    int            n_edges = 0;
    logic [BW-1:0] cap = '0;
    logic [BW-1:0] s_word = '0;
    logic          cpha_t = 1'b0;
    logic          cpol_t = 1'b0;
    bit            mon_en = 1'b0;
    logic          sclk_prev = 1'b0;
    logic          tick_prev = 1'b1;
    int            tick_mode = 0;
    int            cyc = 0;
    logic [BW-1:0] prev_rd = '0;

    spi_xfer_engine #(.WORD_W(BW)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cpol    (cpol),
        .cpha    (cpha),
        .start   (start),
        .wr_word (wr_word),
        .rd_word (rd_word),
        .ready   (ready),
        .sclk    (sclk),
        .mosi    (mosi),
        .miso    (miso)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Slave model, strobe driver and watchdog, all at the falling edge.
    always @(negedge clk) begin
        int idx;
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (rst_n && mon_en && (sclk != sclk_prev)) begin
            // R4: an edge is only legal after a strobe cycle
            chk(tick_prev == 1'b1, "R4", "sclk toggled without tick_en", 0, 1);
            if (cpha_t ? (n_edges % 2 == 1) : (n_edges % 2 == 0))
                cap = {cap[BW-2:0], mosi};
            n_edges++;
        end
        sclk_prev = sclk;
        idx = cpha_t ? (n_edges / 2) : ((n_edges + 1) / 2);
        miso = (idx < BW) ? s_word[BW-1-idx] : 1'b0;
        tick_en = (tick_mode == 0) ? 1'b1 : (cyc % 3 == 0);
        tick_prev = tick_en;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic xfer(input logic [BW-1:0] w, input logic [BW-1:0] s, input bit poke);
        int  k;
        bit  rd_moved;
        s_word  = s;
        cap     = '0;
        n_edges = 0;
        cpha_t  = cpha;
        cpol_t  = cpol;
        mon_en  = 1'b1;
        chk(ready == 1'b1, "R2", "ready before start", int'(ready), 1);
        wr_word = w;
        start   = 1'b1;
        step();
        start   = 1'b0;
        wr_word = ~w;
        chk(ready == 1'b0, "R2", "ready low after accept", int'(ready), 0);
        k = 0;
        rd_moved = 1'b0;
        while (!ready && k < 500) begin
            if (rd_word != prev_rd) rd_moved = 1'b1;
            if (poke && k == 2) begin
                start = 1'b1; cpol = ~cpol_t; cpha = ~cpha_t;
            end
            if (poke && k == 3) begin
                start = 1'b0; cpol = cpol_t; cpha = cpha_t;
            end
            step();
            k++;
        end
        chk(k < 500, "R5", "transfer completed", k, 0);
        chk(rd_word == s, "R7", "received word", int'(rd_word), int'(s));
        chk(cap == w, "R6", "slave-captured word", int'(cap), int'(w));
        chk(n_edges == 2 * BW, "R5", "edge count", n_edges, 2 * BW);
        chk(sclk == cpol_t, "R5", "sclk rest level", int'(sclk), int'(cpol_t));
        chk(!rd_moved, "R8", "rd_word stable during transfer", int'(rd_moved), 0);
        if (poke) begin
            chk(cap == w && n_edges == 2 * BW, "R3", "busy start/mode poke ignored",
                int'(cap), int'(w));
        end
        mon_en  = 1'b0;
        prev_rd = rd_word;
    endtask

    initial begin
        cpol = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
        chk(sclk == 1'b1, "R1", "sclk idles at cpol=1", int'(sclk), 1);
        chk(rd_word == '0, "R1", "rd_word after reset", int'(rd_word), 0);
        chk(mosi == 1'b0, "R1", "mosi after reset", int'(mosi), 0);
        cpol = 1'b0;
        step();
        chk(sclk == 1'b0, "R1", "sclk follows cpol while idle", int'(sclk), 0);
        step();
        sclk_prev = sclk;

        for (int m = 0; m < 4; m++) begin
            for (int tm = 0; tm < 2; tm++) begin
                cpol = m[1];
                cpha = m[0];
                tick_mode = tm;
                step();
                step();
                for (int w = 0; w < (1 << BW); w++) begin
                    logic [BW-1:0] wv;
                    logic [BW-1:0] sv;
                    wv = BW'(w);
                    sv = BW'(w * 7 + m * 3 + tm + 5);
                    xfer(wv, sv, (w == 9));
                    if (w % 2 == 1) begin
                        step();
                        step();
                        chk(rd_word == sv, "R8", "rd_word held while idle",
                            int'(rd_word), int'(sv));
                        chk(sclk == cpol, "R1", "sclk at cpol in idle gap",
                            int'(sclk), int'(cpol));
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule